// File: doc/BRIEF.md
# Two-Wire Serial Slave with Register Bank Access

This block lets a host on a two-wire serial bus read and write an internal bank of 128 eight-bit registers. It oversamples the clock and data lines with the system clock and recognises START, repeated START and STOP conditions. It compares the received device address, whose two low bits come from strap inputs, with its own, and acknowledges each byte it accepts by pulling the data line low through an open-drain output enable. The first byte after a write-addressed device byte sets a 7-bit register pointer. That pointer sits in bits [7:1] of the byte; bit 0 is ignored. Each later byte is written to the bank at the pointer. A read-addressed device byte makes the block shift out register contents, most significant bit first.

After every data byte written, and after every byte sent, the pointer moves to the next register and wraps from 127 to 0. Registers flagged in a 128-bit hold mask keep the pointer in place, so repeated bytes stream through one indirect port. The pointer survives STOP and repeated START, so a read normally begins with a short write that sets the pointer.

States: `ST_IDLE` (bus free), `ST_DEV` (device byte), `ST_REG` (pointer byte), `ST_WDATA` (write data byte), `ST_ACK` (slave acknowledge, two halves), `ST_RD` (sending a byte), `ST_RACK` (master acknowledge bit), `ST_RNEXT` (load the next read byte), `ST_WAIT` (ignore the bus until START or STOP).

Transitions:
- START in any state leads to `ST_DEV`. STOP in any state leads to `ST_IDLE`.
- `ST_DEV` leads to `ST_ACK` when the address matches, and to `ST_WAIT` when it does not.
- `ST_REG` and `ST_WDATA` lead to `ST_ACK` after 8 bits.
- `ST_ACK` leads on to `ST_REG`, `ST_WDATA` or `ST_RD`.
- `ST_RD` leads to `ST_RACK` after 8 bits.
- `ST_RACK` leads to `ST_RNEXT` on an ACK and to `ST_WAIT` on a NACK.
- `ST_RNEXT` leads to `ST_RD`.

Top module: `i2cs_reg_slave`

## Requirements
- R1: A START or repeated START in any state restarts device-address reception, and STOP returns the block to idle. Neither changes the register pointer, so a read after either condition starts at the pointer last set or reached.
- R2: The device address is {DEV_HI, strap_i[1:0]} (7 bits) and occupies bits [7:1] of the first byte; bit 0 is R/W (0 write, 1 read). On a match the slave holds SDA low during the ninth clock.
- R3: On a device address mismatch the slave gives no ACK, performs no bank write and drives nothing until the next START.
- R4: The byte after a write-addressed device byte loads the pointer with bits [7:1] of that byte; bit 0 has no effect.
- R5: Each later byte of a write is acknowledged and produces one rb_wr_en pulse with rb_wr_addr equal to the current pointer and rb_wr_data equal to the byte. The pointer then advances.
- R6: After a read-addressed device byte, the slave sends rb_rd_data at the pointer MSB first. The pointer advances after every byte sent, and each byte the master acknowledges is followed by the next register.
- R7: A master NACK after a read byte ends the transfer. The slave keeps SDA released for all further clocks until a START, after which it responds normally.
- R8: When the pointer addresses a register whose bit in HOLD_MASK is 1, it does not advance after a data byte, in both reads and writes.
- R9: The pointer wraps from 127 to 0.
- R10: The output enable changes only while SCL is low, except when it is released at a START or STOP.
- R11: After reset, SDA is released and no bank write is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 2 | Low device address bits from strap pins |
| rb_rd_addr | output | 7 | Register bank read address (the pointer) |
| rb_rd_data | input | 8 | Register bank read data for rb_rd_addr, combinational |
| rb_wr_en | output | 1 | One-cycle register bank write strobe |
| rb_wr_addr | output | 7 | Register bank write address |
| rb_wr_data | output | 8 | Register bank write data |

## Verification
The write strobe and the pointer step come from the same SCL edge and land in the same clock cycle, so the write must carry the address from before the step. This matters most when the step wraps or stalls on a held register. The bench provokes it with a long block write that starts near the top of the bank, runs through 127 to 0 and ends on a held register. After each byte it compares the captured write address and data with a pointer model computed in the bench. Reads are judged the same way: block and single-byte reads cross the wrap and the held registers, and the returned bytes are checked against a bank model.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W  = 8;
    localparam int PTR_W   = BYTE_W - 1;
    localparam int REG_CNT = 2 ** PTR_W;
    localparam int DEV_W   = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_WDATA,
        ST_ACK,
        ST_RD,
        ST_RACK,
        ST_RNEXT,
        ST_WAIT
    } i2cs_state_t;
endpackage

// File: rtl/i2cs_bus_sense.sv
module i2cs_bus_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain[i] <= 1'b1;
                    sda_chain[i] <= 1'b1;
                end else begin
                    scl_chain[i] <= scl_i;
                    sda_chain[i] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain[i] <= 1'b1;
                    sda_chain[i] <= 1'b1;
                end else begin
                    scl_chain[i] <= scl_chain[i-1];
                    sda_chain[i] <= sda_chain[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_chain[STAGES-1];
            sda_q <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
    assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr import i2cs_pkg::*; #(
    parameter logic [REG_CNT-1:0] HOLD_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    logic held;
    assign held = HOLD_MASK[ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step && !held) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R8: a held register keeps the pointer in place
    a_r8_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && held) |=> (ptr == $past(ptr)));

    // R5: an ordinary step moves to the next register
    a_r5_step_next: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !held) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R9: the top register steps to zero
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !held && ptr == PTR_W'(REG_CNT - 1)) |=> (ptr == '0));
endmodule

// File: rtl/i2cs_reg_slave.sv
module i2cs_reg_slave import i2cs_pkg::*; #(
    parameter int                       STRAP_W     = 2,
    parameter logic [DEV_W-STRAP_W-1:0] DEV_HI      = (DEV_W-STRAP_W)'(6),
    parameter logic [REG_CNT-1:0]       HOLD_MASK   = '0,
    parameter int                       SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [PTR_W-1:0]   rb_rd_addr,
    input  logic [BYTE_W-1:0]  rb_rd_data,
    output logic               rb_wr_en,
    output logic [PTR_W-1:0]   rb_wr_addr,
    output logic [BYTE_W-1:0]  rb_wr_data
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    i2cs_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2cs_state_t         state_q, state_d, ack_next_q;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [BYTE_W-1:0]   shreg_q;
    logic                ack_phase_q;
    logic [BYTE_W-1:0]   byte_in;
    logic                last_bit, dev_match, ptr_load, ptr_step;
    logic [PTR_W-1:0]    ptr;

    assign byte_in   = {shreg_q[BYTE_W-2:0], sda_s};
    assign last_bit  = (bit_cnt_q == CNT_W'(BYTE_W - 1));
    assign dev_match = (byte_in[BYTE_W-1:1] == {DEV_HI, strap_i});
    assign ptr_load  = (state_q == ST_REG) && scl_rise && last_bit;
    assign ptr_step  = ((state_q == ST_WDATA) && scl_rise && last_bit) ||
                       ((state_q == ST_RD) && scl_fall && last_bit);

    i2cs_ptr #(.HOLD_MASK(HOLD_MASK)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (byte_in[BYTE_W-1:1]),
        .step     (ptr_step),
        .ptr      (ptr)
    );

    assign rb_rd_addr = ptr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_start) begin
            state_d = ST_DEV;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_DEV: begin
                    if (scl_rise && last_bit) state_d = dev_match ? ST_ACK : ST_WAIT;
                end
                ST_REG, ST_WDATA: begin
                    if (scl_rise && last_bit) state_d = ST_ACK;
                end
                ST_ACK: begin
                    if (scl_fall && ack_phase_q) state_d = ack_next_q;
                end
                ST_RD: begin
                    if (scl_fall && last_bit) state_d = ST_RACK;
                end
                ST_RACK: begin
                    if (scl_rise) state_d = sda_s ? ST_WAIT : ST_RNEXT;
                end
                ST_RNEXT: begin
                    if (scl_fall) state_d = ST_RD;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // Shift register, bit counter and acknowledge bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            ack_phase_q <= 1'b0;
            ack_next_q  <= ST_REG;
        end else if (bus_start || bus_stop) begin
            bit_cnt_q   <= '0;
            ack_phase_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_REG, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_q   <= byte_in;
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (last_bit) begin
                            if (state_q == ST_DEV)
                                ack_next_q <= byte_in[0] ? ST_RD : ST_REG;
                            else
                                ack_next_q <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ack_phase_q <= ~ack_phase_q;
                        if (ack_phase_q && ack_next_q == ST_RD) shreg_q <= rb_rd_data;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RNEXT: begin
                    if (scl_fall) shreg_q <= rb_rd_data;
                end
                default: ;
            endcase
        end
    end

    // Outputs: SDA drive and register bank write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe     <= 1'b0;
            rb_wr_en   <= 1'b0;
            rb_wr_addr <= '0;
            rb_wr_data <= '0;
        end else begin
            rb_wr_en <= 1'b0;
            if (bus_start || bus_stop) begin
                sda_oe <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_WDATA: begin
                        if (scl_rise && last_bit) begin
                            rb_wr_en   <= 1'b1;
                            rb_wr_addr <= ptr;
                            rb_wr_data <= byte_in;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_phase_q)
                                sda_oe <= 1'b1;
                            else if (ack_next_q == ST_RD)
                                sda_oe <= ~rb_rd_data[BYTE_W-1];
                            else
                                sda_oe <= 1'b0;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) sda_oe <= last_bit ? 1'b0 : ~shreg_q[BYTE_W-2];
                    end
                    ST_RNEXT: begin
                        if (scl_fall) sda_oe <= ~rb_rd_data[BYTE_W-1];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: drive changes only while SCL is low, apart from release at START/STOP
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!scl_s || $past(bus_start || bus_stop)));

    // R1: a START always restarts device address reception
    a_r1_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_start) |-> (state_q == ST_DEV));

    // R3 / R7: idle and ignoring states never drive SDA
    a_r7_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT || state_q == ST_IDLE) |-> !sda_oe);

    // R5: a bank write only follows a completed write data byte
    a_r5_wr_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        rb_wr_en |-> ($past(state_q) == ST_WDATA));

    // R3: a non-addressed slave never writes
    a_r3_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) == ST_WAIT) |-> !rb_wr_en);
endmodule

// File: tb/i2cs_reg_slave_tb.sv
module i2cs_reg_slave_tb;
    localparam int Q = 8;
    localparam logic [4:0] HI = 5'b10011;
    localparam logic [127:0] HOLD = (128'd1 << 16) | (128'd1 << 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'd0;
    logic sda_oe;
    logic sda_line;
    logic [6:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic wr_en;

    logic [7:0] bank [128];
    logic [7:0] expv [128];
    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int hi_chg = 0;
    logic oe_prev = 1'b0;
    logic [6:0] last_wa = '0;
    logic [7:0] last_wd = '0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data = bank[rd_addr];

    i2cs_reg_slave #(.DEV_HI(HI), .HOLD_MASK(HOLD)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .strap_i    (strap),
        .rb_rd_addr (rd_addr),
        .rb_rd_data (rd_data),
        .rb_wr_en   (wr_en),
        .rb_wr_addr (wr_addr),
        .rb_wr_data (wr_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 128; k++) bank[k] <= 8'(k * 13) ^ 8'h5A;
        end else if (wr_en) begin
            bank[wr_addr] <= wr_data;
        end
    end

    always @(posedge clk) begin
        oe_prev <= sda_oe;
        if (rst_n && (sda_oe != oe_prev) && scl_m) hi_chg <= hi_chg + 1;
        if (rst_n && wr_en) begin
            wr_cnt  <= wr_cnt + 1;
            last_wa <= wr_addr;
            last_wd <= wr_data;
        end
    end

    function automatic int nxt(input int p);
        return HOLD[p] ? p : (p + 1) % 128;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic d, output logic s);
        sda_m = d;
        wq();
        scl_m = 1'b1;
        wq();
        s = sda_line;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            b[i] = s;
        end
        bit_cycle(!mack, s);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        bit ack;
        logic [7:0] b;
        logic s;
        int p, w0;
        logic [6:0] a;
        logic [7:0] v;
        string tag;

        for (int k = 0; k < 128; k++) expv[k] = 8'(k * 13) ^ 8'h5A;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state
        chk(sda_oe == 1'b0, "R11 sda released", int'(sda_oe), 0);
        chk(wr_cnt == 0, "R11 no write", wr_cnt, 0);

        // R2 / R3: address sweep over straps and candidate addresses
        for (int st = 0; st < 4; st++) begin
            strap = 2'(st);
            wq();
            for (int t = 0; t < 6; t++) begin
                if (t < 4) a = {HI, 2'(t)};
                else if (t == 4) a = {HI ^ 5'b00001, 2'(st)};
                else a = {HI ^ 5'b10000, 2'(st)};
                w0 = wr_cnt;
                bus_start();
                send_byte({a, 1'b0}, ack);
                if (a == {HI, 2'(st)}) begin
                    chk(ack == 1'b1, "R2 match ack", int'(ack), 1);
                end else begin
                    chk(ack == 1'b0, "R3 mismatch no ack", int'(ack), 0);
                    send_byte(8'h22, ack);
                    chk(ack == 1'b0, "R3 ignored byte", int'(ack), 0);
                    chk(wr_cnt == w0, "R3 no write", wr_cnt, w0);
                end
                bus_stop();
            end
        end
        strap = 2'd2;
        wq();

        // R4 / R5 / R8 / R9: block write across wrap onto a held register
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        chk(ack, "R2 write addr ack", int'(ack), 1);
        send_byte({7'd120, 1'b1}, ack);
        chk(ack, "R4 pointer byte ack", int'(ack), 1);
        p = 120;
        w0 = wr_cnt;
        for (int i = 0; i < 14; i++) begin
            v = 8'(i * 37 + 11);
            send_byte(v, ack);
            tag = (i >= 12) ? "R8" : ((i >= 8) ? "R9" : "R5");
            chk(ack, {tag, " data ack"}, int'(ack), 1);
            chk(last_wa == 7'(p), {tag, " write addr"}, int'(last_wa), p);
            chk(last_wd == v, {tag, " write data"}, int'(last_wd), int'(v));
            expv[p] = v;
            p = nxt(p);
        end
        chk(wr_cnt == w0 + 14, "R5 write count", wr_cnt, w0 + 14);
        bus_stop();

        // R6 / R9 / R8 / R1: block read after repeated START
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        send_byte({7'd118, 1'b0}, ack);
        chk(ack, "R4 pointer ack", int'(ack), 1);
        bus_start();
        send_byte({HI, 2'd2, 1'b1}, ack);
        chk(ack, "R6 read addr ack", int'(ack), 1);
        p = 118;
        for (int i = 0; i < 16; i++) begin
            recv_byte(i != 15, b);
            tag = (i >= 13) ? "R8" : ((i >= 10) ? "R9" : "R6");
            chk(b == expv[p], {tag, " read data"}, int'(b), int'(expv[p]));
            p = nxt(p);
        end

        // R7: after NACK the slave stays off the bus
        begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 9; i++) begin
                bit_cycle(1'b1, s);
                if (s !== 1'b1) quiet = 1'b0;
            end
            chk(quiet, "R7 released after nack", int'(quiet), 1);
        end
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        chk(ack, "R7 recovers on start", int'(ack), 1);
        bus_stop();

        // R8: reads at a held register repeat it
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        send_byte({7'd16, 1'b0}, ack);
        bus_start();
        send_byte({HI, 2'd2, 1'b1}, ack);
        for (int i = 0; i < 3; i++) begin
            recv_byte(i != 2, b);
            chk(b == expv[16], "R8 held read", int'(b), int'(expv[16]));
        end
        bus_stop();

        // R8: writes at a held register stay there
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        send_byte({7'd16, 1'b1}, ack);
        send_byte(8'h77, ack);
        chk(last_wa == 7'd16, "R8 held write 1", int'(last_wa), 16);
        send_byte(8'h78, ack);
        chk(last_wa == 7'd16, "R8 held write 2", int'(last_wa), 16);
        expv[16] = 8'h78;
        bus_stop();

        // R1: pointer kept across STOP
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        send_byte({7'd50, 1'b0}, ack);
        bus_stop();
        bus_start();
        send_byte({HI, 2'd2, 1'b1}, ack);
        recv_byte(1'b0, b);
        chk(b == expv[50], "R1 pointer kept over stop", int'(b), int'(expv[50]));
        bus_stop();

        // R1: repeated START inside a write keeps the advanced pointer
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        send_byte({7'd60, 1'b0}, ack);
        send_byte(8'h3C, ack);
        expv[60] = 8'h3C;
        bus_start();
        send_byte({HI, 2'd2, 1'b1}, ack);
        recv_byte(1'b0, b);
        chk(b == expv[61], "R1 pointer kept over restart", int'(b), int'(expv[61]));
        bus_stop();

        // R8 / R5: read back the held register contents written earlier
        bus_start();
        send_byte({HI, 2'd2, 1'b0}, ack);
        send_byte({7'd16, 1'b0}, ack);
        bus_start();
        send_byte({HI, 2'd2, 1'b1}, ack);
        recv_byte(1'b0, b);
        chk(b == 8'h78, "R8 held register value", int'(b), 'h78);
        bus_stop();

        // R10: no drive change while SCL high
        chk(hi_chg == 0, "R10 oe change with scl high", hi_chg, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule